// File: doc/BRIEF.md
# Ethernet Transmit Framer

This block turns a frame's worth of bytes, waiting in a transmit FIFO, into a nibble-wide stream for a media-independent interface. It stays idle until two things are true at once: the FIFO holds at least a programmed number of bytes, and the channel-permit input is high. It then drives the preamble and start delimiter and reads the payload out of the FIFO one byte at a time. Each byte goes out as two nibbles. It can add zero bytes to reach the minimum frame size, and it ends the frame with a CRC-32 check sequence that it computes itself.

The FIFO is outside the block and shows its head entry directly: a data byte, a flag that marks the last byte of the frame, and the current fill level. The framer pops an entry with a one-cycle read strobe. The whole frame must be in the FIFO before the threshold releases it. Padding and check-sequence generation are chosen per frame by two inputs, which the framer samples in the cycle it starts.

Top module: `eth_tx_framer`

## Requirements
- R1: After reset, and while no frame is in progress, `mii_txen` is 0, `mii_txd` is 0 and `fifo_rd` is 0. No frame starts while `fifo_level` is below `start_thresh`, while `fifo_level` is 0, or while `chan_ok` is 0.
- R2: When a clock edge finds `chan_ok` high and `fifo_level` nonzero and at least `start_thresh`, `mii_txen` is high from that edge on.
- R3: A frame opens with 15 nibbles of 4'h5 followed by one nibble of 4'hD. This is seven bytes of 8'h55 and a delimiter byte of 8'hD5, each sent low nibble first.
- R4: Payload bytes follow in FIFO order. Each byte is popped exactly once and sent low nibble first. The entry whose last flag is set is the final payload byte.
- R5: With padding selected and fewer than MIN_DATA (60) payload bytes, 8'h00 bytes follow the payload until the payload and padding together reach MIN_DATA bytes.
- R6: With padding deselected, or with a payload of MIN_DATA bytes or more, no pad bytes are sent, so even a short frame goes out unpadded.
- R7: With the check sequence selected, four bytes follow the payload and padding. They are the complement of a CRC-32 (polynomial 0x04C11DB7 in reflected form 0xEDB88320, preset to all ones) over the payload and pad bytes, sent least significant byte first, low nibble first.
- R8: With the check sequence deselected, the frame ends after the last payload or pad byte.
- R9: Changes to `pad_en` and `fcs_en` after a frame has started have no effect on that frame.
- R10: `mii_txen` stays high without a gap from the first preamble nibble through the last nibble of the frame, and then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_level | input | LVL_W | Number of bytes held in the transmit FIFO |
| fifo_byte | input | 8 | Data byte at the FIFO head |
| fifo_last | input | 1 | Head entry is the last byte of its frame |
| fifo_rd | output | 1 | Pops the head entry at the next clock edge |
| start_thresh | input | LVL_W | Fill level that releases a frame |
| chan_ok | input | 1 | Channel access is currently permitted |
| pad_en | input | 1 | Pad short frames with zero bytes |
| fcs_en | input | 1 | Append the generated check sequence |
| mii_txd | output | 4 | Transmit nibble |
| mii_txen | output | 1 | Transmit enable |

## Verification
The bench builds the block with LVL_W = 8 and MIN_DATA = 60. This puts the real pad boundary in reach: payloads of 59, 60 and 61 bytes sit on either side of it. An 8-bit level lets a single 100-byte frame sit in the FIFO before the threshold releases it. Vectors cover every combination of the pad and check-sequence selects. Directed runs hold a loaded frame back on the threshold and on the channel permit, and they toggle the selects in the middle of a frame.

// File: rtl/eth_tx_framer.sv
module eth_tx_framer #(
  parameter int LVL_W    = 8,
  parameter int MIN_DATA = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [7:0]       fifo_byte,
  input  logic             fifo_last,
  output logic             fifo_rd,
  input  logic [LVL_W-1:0] start_thresh,
  input  logic             chan_ok,
  input  logic             pad_en,
  input  logic             fcs_en,
  output logic [3:0]       mii_txd,
  output logic             mii_txen
);

  localparam int LEN_W = $clog2(MIN_DATA + 1);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_DATA);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SFD, S_DATA, S_PAD, S_FCS} st_t;

  st_t              state;
  logic             hi;
  logic [2:0]       cnt;
  logic [7:0]       cur;
  logic [31:0]      crc, fcs_sr;
  logic [LEN_W-1:0] len;
  logic             last_q, pad_q, fcs_q;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++)
      r = (r[0] ^ d[i]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
    return r;
  endfunction

  wire              start    = chan_ok && (fifo_level != '0) && (fifo_level >= start_thresh);
  wire              need_pad = pad_q && (len < MIN_L);
  wire [31:0]       fcs_val  = ~crc;
  wire [LEN_W-1:0]  len_inc  = (len == MIN_L) ? len : len + 1'b1;
  wire              take     = (state == S_SFD) || (state == S_DATA && !last_q);

  assign fifo_rd  = hi && take;
  assign mii_txen = state != S_IDLE;
  assign mii_txd  = mii_txen ? (hi ? cur[7:4] : cur[3:0]) : 4'h0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; hi <= 1'b0; cnt <= '0; cur <= '0;
      crc <= '1; fcs_sr <= '0; len <= '0;
      last_q <= 1'b0; pad_q <= 1'b0; fcs_q <= 1'b0;
    end else if (state == S_IDLE) begin
      hi <= 1'b0;
      if (start) begin
        state <= S_PRE; cnt <= '0; cur <= 8'h55; crc <= '1; len <= '0;
        pad_q <= pad_en; fcs_q <= fcs_en;
      end
    end else if (!hi) begin
      hi <= 1'b1;
    end else begin
      hi <= 1'b0;
      case (state)
        S_PRE:
          if (cnt == 3'd6) begin
            state <= S_SFD; cur <= 8'hD5;
          end else cnt <= cnt + 3'd1;
        S_SFD, S_DATA, S_PAD:
          if (take) begin
            state <= S_DATA; cur <= fifo_byte; last_q <= fifo_last;
            crc <= crc_step(crc, fifo_byte); len <= len_inc;
          end else if (need_pad) begin
            state <= S_PAD; cur <= 8'h00;
            crc <= crc_step(crc, 8'h00); len <= len_inc;
          end else if (fcs_q) begin
            state <= S_FCS; cnt <= '0; cur <= fcs_val[7:0];
            fcs_sr <= {8'h00, fcs_val[31:8]};
          end else state <= S_IDLE;
        S_FCS:
          if (cnt == 3'd3) state <= S_IDLE;
          else begin
            cnt <= cnt + 3'd1; cur <= fcs_sr[7:0]; fcs_sr <= fcs_sr >> 8;
          end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_txen) |-> $past(chan_ok && fifo_level != '0 && fifo_level >= start_thresh));

  a_r3_first_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_txen) |-> mii_txd == 4'h5);

  a_r4_pop_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> (mii_txen && fifo_level != '0));

  a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_PAD |-> (mii_txd == 4'h0 && pad_q));

  a_r8_fcs_selected: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FCS |-> fcs_q);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !mii_txen |-> (mii_txd == 4'h0 && !fifo_rd));

endmodule

// File: tb/eth_tx_framer_tb.sv
module eth_tx_framer_tb;
  localparam int LVL_W = 8;
  localparam int MIN_DATA = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [LVL_W-1:0] fifo_level, start_thresh;
  logic [7:0] fifo_byte;
  logic fifo_last, fifo_rd, chan_ok, pad_en, fcs_en, mii_txen;
  logic [3:0] mii_txd;

  always #2 clk = ~clk;

  eth_tx_framer #(.LVL_W(LVL_W), .MIN_DATA(MIN_DATA)) u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_level(fifo_level), .fifo_byte(fifo_byte),
    .fifo_last(fifo_last), .fifo_rd(fifo_rd), .start_thresh(start_thresh),
    .chan_ok(chan_ok), .pad_en(pad_en), .fcs_en(fcs_en),
    .mii_txd(mii_txd), .mii_txen(mii_txen));

  logic [8:0] mem [0:511];
  logic [8:0] wp = '0, rp = '0;
  wire  [8:0] occ = wp - rp;
  assign fifo_level = occ[LVL_W-1:0];
  assign fifo_byte  = mem[rp][7:0];
  assign fifo_last  = mem[rp][8];
  always @(posedge clk) if (fifo_rd) rp <= rp + 9'd1;

  int checks = 0, fails = 0;
  int nib [0:1023];
  int nn;
  logic [7:0] eb [0:255];
  int ne, npad;

  // {len[7:0], pad, fcs, seed[7:0]}
  localparam logic [17:0] VEC [9] = '{
    {8'd1,   1'b1, 1'b1, 8'h11}, {8'd59,  1'b1, 1'b1, 8'h22},
    {8'd60,  1'b1, 1'b1, 8'h33}, {8'd61,  1'b1, 1'b1, 8'h44},
    {8'd10,  1'b0, 1'b1, 8'h55}, {8'd10,  1'b1, 1'b0, 8'h66},
    {8'd5,   1'b0, 1'b0, 8'h77}, {8'd64,  1'b0, 1'b0, 8'h88},
    {8'd100, 1'b1, 1'b1, 8'h99}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input int len, input logic [7:0] seed, input int from);
    for (int i = from; i < len; i++) begin
      mem[wp] = {(i == len - 1), 8'(seed + i * 37)};
      wp = wp + 9'd1;
    end
  endtask

  task automatic build_exp(input int len, input bit pad, input bit fcs, input logic [7:0] seed);
    logic [31:0] c;
    ne = 0; npad = 0;
    for (int i = 0; i < len; i++) begin eb[ne] = 8'(seed + i * 37); ne++; end
    if (pad) while (ne < MIN_DATA) begin eb[ne] = 8'h00; ne++; npad++; end
    c = 32'hFFFFFFFF;
    for (int i = 0; i < ne; i++)
      for (int b = 0; b < 8; b++)
        c = (c[0] ^ eb[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    c = ~c;
    if (fcs) for (int k = 0; k < 4; k++) begin eb[ne] = c[8*k +: 8]; ne++; end
  endtask

  function automatic int exp_nib(input int j);
    if (j < 15) return 5;
    if (j == 15) return 13;
    return (j % 2 == 0) ? int'(eb[(j-16)/2][3:0]) : int'(eb[(j-16)/2][7:4]);
  endfunction

  task automatic region(input int lo, input int hi_i, input string tag);
    int bad_idx = -1;
    for (int j = lo; j < hi_i; j++)
      if (bad_idx < 0 && (j >= nn || nib[j] != exp_nib(j))) bad_idx = j;
    check(bad_idx < 0, tag, (bad_idx < 0 || bad_idx >= nn) ? -1 : nib[bad_idx],
          bad_idx < 0 ? 0 : exp_nib(bad_idx));
  endtask

  task automatic collect(input bit flip);
    int w = 0;
    nn = 0;
    while (!mii_txen && w < 1000) begin @(negedge clk); w++; end
    if (flip) begin pad_en = ~pad_en; fcs_en = ~fcs_en; end
    while (mii_txen && nn < 1024) begin nib[nn] = mii_txd; nn++; @(negedge clk); end
  endtask

  task automatic verify(input int len, input bit pad, input bit fcs, input logic [7:0] seed);
    int p0;
    build_exp(len, pad, fcs, seed);
    p0 = 16 + 2 * len;
    check(nn == 16 + 2 * ne, fcs ? (npad > 0 ? "R10 R5 length" : "R10 R6 length") : "R10 R8 length",
          nn, 16 + 2 * ne);
    region(0, 16, "R3 preamble");
    region(16, p0, "R4 payload");
    if (npad > 0) region(p0, p0 + 2 * npad, "R5 pad");
    if (fcs) region(p0 + 2 * npad, 16 + 2 * ne, "R7 fcs");
    check(wp == rp, "R4 pops", int'(rp), int'(wp));
    check(!mii_txen, "R10 end", int'(mii_txen), 0);
  endtask

  task automatic run(input int len, input bit pad, input bit fcs, input logic [7:0] seed, input bit flip);
    chan_ok = 1'b0;
    push(len, seed, 0);
    start_thresh = LVL_W'(len);
    pad_en = pad; fcs_en = fcs;
    @(negedge clk);
    chan_ok = 1'b1;
    collect(flip);
    chan_ok = 1'b0;
    verify(len, pad, fcs, seed);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    chan_ok = 1'b0; pad_en = 1'b0; fcs_en = 1'b0; start_thresh = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!mii_txen && mii_txd == 4'h0 && !fifo_rd, "R1 reset", {mii_txen, mii_txd, fifo_rd}, 0);

    foreach (VEC[i]) run(int'(VEC[i][17:10]), VEC[i][9], VEC[i][8], VEC[i][7:0], 1'b0);

    // R1/R2: threshold gating with channel permitted
    pad_en = 1'b1; fcs_en = 1'b1; start_thresh = 8'd10; chan_ok = 1'b1;
    push(9, 8'hA0, 0);
    for (int i = 0; i < 9; i++) begin mem[wp - 9'd9 + 9'(i)][8] = 1'b0; end
    repeat (20) @(negedge clk);
    check(!mii_txen, "R1 below threshold", int'(mii_txen), 0);
    mem[wp] = {1'b1, 8'(8'hA0 + 9 * 37)}; wp = wp + 9'd1;
    @(negedge clk);
    check(mii_txen, "R2 start timing", int'(mii_txen), 1);
    collect(1'b0);
    chan_ok = 1'b0;
    verify(10, 1'b1, 1'b1, 8'hA0);

    // R1/R2: channel permit gating with a full frame waiting
    push(12, 8'hB0, 0);
    start_thresh = 8'd12; pad_en = 1'b0; fcs_en = 1'b1;
    repeat (20) @(negedge clk);
    check(!mii_txen && !fifo_rd, "R1 no permit", int'(mii_txen), 0);
    chan_ok = 1'b1;
    @(negedge clk);
    check(mii_txen, "R2 permit start", int'(mii_txen), 1);
    collect(1'b0);
    chan_ok = 1'b0;
    verify(12, 1'b0, 1'b1, 8'hB0);

    // R9: selects toggled after start
    run(20, 1'b1, 1'b1, 8'hC5, 1'b1);
    run(20, 1'b0, 1'b0, 8'hD6, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule